// File: doc/BRIEF.md
# Prioritised Interrupt Signalling Port with Nested Preemption

This block sits between an interrupt distributor and one processor. The distributor presents a vector of pending, enabled interrupt lines, each with an 8-bit priority. The block selects the most urgent line that is not already being serviced. It drives a single registered interrupt request to the processor when that line passes three tests: a programmable priority threshold, a global enable, and a preemption rule that compares priority groups against the priority currently running.

Software uses a small word-addressed register port. Reading the claim register takes the selected interrupt: the line is marked in service and its priority is pushed onto a small stack of running priorities. Writing that same ID to the retire register pops the stack, and this allows nested handlers. A claim read when nothing qualifies returns the reserved ID 1023 and has no other effect. The preemption rule ignores priority bits below a programmable split point, and the highest split value turns preemption off.

Top module: `irq_cpu_port`

## Requirements
- R1: After reset `irq_o` is low, and reads of control (word 0), threshold (word 1) and split point (word 2) return 0. The running-priority register (word 5) returns 0xFF, which means nothing is in service.
- R2: Only the upper PRIO_BITS bits of any priority exist. Lower bits of incoming priorities are treated as zero, and they read back as zero from the threshold register.
- R3: The selected candidate is the pending line that is not in service and has the numerically smallest priority. When priorities are equal, the lowest ID wins.
- R4: A candidate is signalled only if its priority is strictly below the threshold register value (word 1, bits 7:0).
- R5: Control bit 0 is the enable. While it is clear, `irq_o` stays low and a claim read returns 1023.
- R6: A claim read (word 3, ID in bits 9:0) that finds no qualifying candidate returns 1023 and changes no state.
- R7: While an interrupt is in service and the split point n (word 2, bits 2:0) is 0 to 6, a candidate preempts only if its priority bits 7 down to n+1 form a smaller value than the same bits of the running priority.
- R8: A split point of 7 disables preemption. No request is raised while any interrupt is in service.
- R9: A granted claim read returns the candidate ID, marks that line in service, and pushes its priority. The running-priority register then reads that priority.
- R10: A write to word 4 whose bits 9:0 equal the most recently claimed in-service ID retires that line and pops the stack. Any other value is ignored.
- R11: When STACK_DEPTH interrupts are in service, no request is raised and claim reads return 1023.
- R12: `irq_o` is registered. It is low in the cycle after a claim read, and otherwise it shows one clock later whether a candidate qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | NUM_IRQ | Pending and enabled lines from the distributor |
| prio_i | input | NUM_IRQ*8 | Priority of line k in bits 8k+7:8k |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Word index of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the access |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with NUM_IRQ=8, PRIO_BITS=5 and STACK_DEPTH=2. Five implemented priority bits let the bench show low priority bits being dropped, both in threshold readback and in ties between lines whose raw priorities differ only below bit 3. A two-entry stack fills after one nested claim, so the full-stack refusal and out-of-order retire writes are reached within a few register accesses. The bench sets the split point to 5, 6 and 7 against one fixed pair of running and pending priorities, and this shows the group boundary moving across the preemption decision.

// File: rtl/irq_cpu_port.sv
module irq_cpu_port #(
  parameter int NUM_IRQ     = 32,
  parameter int PRIO_BITS   = 8,
  parameter int STACK_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IRQ-1:0]   pend_i,
  input  logic [NUM_IRQ*8-1:0] prio_i,
  input  logic                 bus_sel_i,
  input  logic                 bus_wr_i,
  input  logic [2:0]           bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  output logic                 irq_o
);
  localparam int IDW = 10;
  localparam int DW  = $clog2(STACK_DEPTH + 1);
  localparam logic [7:0]     PMASK    = 8'hFF << (8 - PRIO_BITS);
  localparam logic [IDW-1:0] SPURIOUS = 10'd1023;
  localparam logic [DW-1:0]  FULL     = DW'(STACK_DEPTH);

  logic                 en_q;
  logic [7:0]           thr_q;
  logic [2:0]           bpt_q;
  logic [DW-1:0]        depth_q;
  logic [NUM_IRQ-1:0]   act_q;
  logic [7:0]           pstk [STACK_DEPTH];
  logic [IDW-1:0]       istk [STACK_DEPTH];
  logic                 irq_q;

  logic [NUM_IRQ-1:0]   cand;
  logic                 best_v;
  logic [IDW-1:0]       best_id;
  logic [7:0]           best_p;
  logic [DW-1:0]        top;
  logic [7:0]           run_p;
  logic [IDW-1:0]       run_id;
  logic [3:0]           shift;
  logic [7:0]           grp;
  logic                 preempt_ok, qual, grant;
  logic                 wr, rd, claim, retire;
  logic                 unused_bits;

  assign cand   = pend_i & ~act_q;
  assign top    = depth_q - 1'b1;
  assign run_p  = (depth_q == '0) ? 8'hFF : pstk[top];
  assign run_id = (depth_q == '0) ? SPURIOUS : istk[top];

  always_comb begin
    best_v  = 1'b0;
    best_id = '0;
    best_p  = 8'hFF;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && (!best_v || (prio_i[i*8 +: 8] & PMASK) < best_p)) begin
        best_v  = 1'b1;
        best_id = IDW'(i);
        best_p  = prio_i[i*8 +: 8] & PMASK;
      end
    end
  end

  assign shift      = {1'b0, bpt_q} + 4'd1;
  assign grp        = 8'hFF << shift;
  assign preempt_ok = (depth_q == '0) ||
                      (bpt_q != 3'd7 && (best_p & grp) < (run_p & grp));
  assign qual       = best_v && (best_p < thr_q) && (depth_q < FULL) && preempt_ok;
  assign grant      = en_q && qual;

  assign wr     = bus_sel_i && bus_wr_i;
  assign rd     = bus_sel_i && !bus_wr_i;
  assign claim  = rd && bus_addr_i == 3'd3 && grant;
  assign retire = wr && bus_addr_i == 3'd4 && depth_q != '0 &&
                  bus_wdata_i[IDW-1:0] == run_id;
  assign unused_bits = ^bus_wdata_i[31:IDW];

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      case (bus_addr_i)
        3'd0:    bus_rdata_o = {31'b0, en_q};
        3'd1:    bus_rdata_o = {24'b0, thr_q};
        3'd2:    bus_rdata_o = {29'b0, bpt_q};
        3'd3:    bus_rdata_o = {22'b0, grant ? best_id : SPURIOUS};
        3'd5:    bus_rdata_o = {24'b0, run_p};
        default: bus_rdata_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      thr_q   <= '0;
      bpt_q   <= '0;
      depth_q <= '0;
      act_q   <= '0;
      irq_q   <= 1'b0;
      for (int k = 0; k < STACK_DEPTH; k++) begin
        pstk[k] <= '0;
        istk[k] <= '0;
      end
    end else begin
      irq_q <= grant && !(rd && bus_addr_i == 3'd3);
      if (wr && bus_addr_i == 3'd0) en_q  <= bus_wdata_i[0];
      if (wr && bus_addr_i == 3'd1) thr_q <= bus_wdata_i[7:0] & PMASK;
      if (wr && bus_addr_i == 3'd2) bpt_q <= bus_wdata_i[2:0];
      if (claim) begin
        pstk[depth_q] <= best_p;
        istk[depth_q] <= best_id;
        depth_q       <= depth_q + 1'b1;
      end
      if (retire) depth_q <= top;
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (claim && best_id == IDW'(i))  act_q[i] <= 1'b1;
        if (retire && run_id == IDW'(i))  act_q[i] <= 1'b0;
      end
    end
  end

  assign irq_o = irq_q;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en_q) |-> !irq_q); // R5
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= FULL); // R11
  AST_CLAIM_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr_i == 3'd3) |=> !irq_o); // R12
  AST_BAD_RETIRE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr_i == 3'd4 && bus_wdata_i[IDW-1:0] != run_id) |=> $stable(depth_q)); // R10
  AST_NO_NEST_AT_SEVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bpt_q == 3'd7 && depth_q != '0 && $stable(depth_q)) |=> !irq_o || $past(depth_q) == '0); // R8
endmodule

// File: tb/test_irq_cpu_port.sv
module test_irq_cpu_port;
  localparam int NI = 8;
  logic          clk = 1'b0;
  logic          rst_n;
  logic [NI-1:0] pend;
  logic [NI*8-1:0] prio;
  logic          sel, wr;
  logic [2:0]    addr;
  logic [31:0]   wdata, rdata;
  logic          irq;
  int            checks = 0;
  int            errors = 0;

  irq_cpu_port #(.NUM_IRQ(NI), .PRIO_BITS(5), .STACK_DEPTH(2)) i_irq_cpu_port (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .prio_i(prio),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq));

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rreg(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #2 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic setp(int id, logic [7:0] p);
    prio[id*8 +: 8] = p;
  endtask

  task automatic do_reset();
    sel = 0; wr = 0; addr = 0; wdata = 0; pend = '0; prio = '0;
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 irq", irq, 0);
    rreg(3'd0, d); chk("R1 ctrl", d, 0);
    rreg(3'd1, d); chk("R1 thr", d, 0);
    rreg(3'd2, d); chk("R1 split", d, 0);
    rreg(3'd5, d); chk("R1 run", d, 32'hFF);
    rreg(3'd3, d); chk("R6 spurious after reset", d, 1023);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    do_reset();
    wreg(3'd1, 32'hFF);
    setp(3, 8'h40); pend[3] = 1'b1;
    idle(2); chk("R5 disabled irq", irq, 0);
    rreg(3'd3, d); chk("R5 disabled claim", d, 1023);
    wreg(3'd0, 1); idle(1);
    chk("R5 enabled irq", irq, 1);
    rreg(3'd0, d); chk("R5 ctrl readback", d, 1);
    wreg(3'd0, 0); idle(1);
    chk("R5 re-disabled irq", irq, 0);
  endtask

  task automatic t_threshold();
    logic [31:0] d;
    do_reset();
    wreg(3'd0, 1);
    setp(3, 8'h40); pend[3] = 1'b1;
    wreg(3'd1, 32'h40); idle(1);
    chk("R4 equal to threshold", irq, 0);
    wreg(3'd1, 32'h48); idle(1);
    chk("R4 below threshold", irq, 1);
    setp(3, 8'h4F); idle(2);
    chk("R2 low prio bits dropped", irq, 0);
    wreg(3'd1, 32'hFF);
    rreg(3'd1, d); chk("R2 threshold readback", d, 32'hF8);
  endtask

  task automatic t_select();
    logic [31:0] d;
    do_reset();
    wreg(3'd0, 1); wreg(3'd1, 32'hFF);
    setp(2, 8'h27); setp(5, 8'h20); setp(3, 8'h40);
    pend[2] = 1; pend[5] = 1; pend[3] = 1;
    idle(2); chk("R12 irq raised", irq, 1);
    rreg(3'd3, d); chk("R3 tie lowest id", d, 2);
    chk("R12 irq low after claim", irq, 0);
    rreg(3'd5, d); chk("R9 running prio", d, 32'h20);
    rreg(3'd3, d); chk("R6 same group no preempt", d, 1023);
    rreg(3'd5, d); chk("R6 no state change", d, 32'h20);
    wreg(3'd4, 2);
    rreg(3'd5, d); chk("R10 retire pops", d, 32'hFF);
    rreg(3'd3, d); chk("R3 reselect", d, 2);
  endtask

  task automatic t_nesting();
    logic [31:0] d;
    do_reset();
    wreg(3'd0, 1); wreg(3'd1, 32'hFF); wreg(3'd2, 5);
    setp(1, 8'hC0); pend[1] = 1;
    idle(2);
    rreg(3'd3, d); chk("R9 first claim", d, 1);
    setp(4, 8'h90); pend[4] = 1;
    idle(2); chk("R7 split 5 preempts", irq, 1);
    wreg(3'd2, 6); idle(1);
    chk("R7 split 6 same group", irq, 0);
    wreg(3'd2, 7); idle(1);
    chk("R8 split 7 blocks", irq, 0);
    setp(4, 8'h00); idle(2);
    chk("R8 split 7 blocks top prio", irq, 0);
    rreg(3'd3, d); chk("R8 claim spurious", d, 1023);
    rreg(3'd2, d); chk("R7 split readback", d, 7);
    setp(4, 8'h90); wreg(3'd2, 5); idle(1);
    rreg(3'd3, d); chk("R9 nested claim", d, 4);
    rreg(3'd5, d); chk("R9 nested running", d, 32'h90);
    setp(6, 8'h00); pend[6] = 1;
    idle(2); chk("R11 full stack irq", irq, 0);
    rreg(3'd3, d); chk("R11 full stack claim", d, 1023);
    pend = '0;
    wreg(3'd4, 1);
    rreg(3'd5, d); chk("R10 mismatched retire ignored", d, 32'h90);
    wreg(3'd4, 4);
    rreg(3'd5, d); chk("R10 retire inner", d, 32'hC0);
    wreg(3'd4, 1);
    rreg(3'd5, d); chk("R10 retire outer", d, 32'hFF);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_enable();
    t_threshold();
    t_select();
    t_nesting();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule